// File: doc/BRIEF.md
# Request-Driven Descriptor Transfer Engine

This block moves one data unit from a source address to a destination address each time a peripheral raises a request line. What each request does is held in memory, not in the block. A vector table in memory holds one word per request source. That word gives the address of the source's transfer descriptor. The descriptor holds a control word, a source address, a destination address and a transfer count. For each request the engine reads the vector entry and the descriptor. It then moves one unit of 1, 2 or 4 bytes and steps the two addresses as the control word says. It decrements the count and writes the updated source address, destination address and count back into the descriptor.

A request is serviced only when the global run input is high and the per-source enable bit of that source is set. Any other request is passed straight to the CPU as a one-cycle interrupt pulse on that source's line. A serviced request also raises the interrupt when the count reaches zero, or when the interrupt-every-transfer bit is set. When the count reaches zero, the source's enable bit is cleared, so later requests from that source go to the CPU. Requests that arrive while a transfer is in progress are held, and the lowest-numbered pending source is serviced first.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset, irq and xfer_en are all zero and mem_req is low.
- R2: A request pulse on req[i] is bypassed when run is low or xfer_en[i] is clear. In that case irq[i] is high in the cycle after the request and no memory access occurs.
- R3: For a serviced request, the engine reads the descriptor base address from the vector word at VEC_BASE + 4*i. The descriptor is four words: +0 control, +4 source address, +8 destination address, +12 count in bits [15:0].
- R4: Control bits [3:2] give the unit size: 00 is one byte, 01 is two bytes, 10 is four bytes. One unit of that size is read at the source address and written at the destination address. Bytes past the unit are left untouched.
- R5: Control bits [5:4] step the source address and bits [7:6] step the destination address. Code 00 or 01 keeps the address fixed, 10 adds the unit size, and 11 subtracts the unit size.
- R6: After each transfer, the count is decremented by one. The stepped source address, stepped destination address and new count are written back to descriptor words +4, +8 and +12.
- R7: When the new count is zero, irq[i] pulses and xfer_en[i] is cleared. Later requests from source i are then bypassed and leave the descriptor unchanged.
- R8: When control bit [9] is 1, irq[i] pulses after every transfer.
- R9: When control bit [9] is 0 and the new count is nonzero, no irq pulse occurs. A starting count of 0 wraps to 0xFFFF.
- R10: Requests arriving while a transfer is in progress are held and serviced afterwards. Among simultaneous pending sources, the lowest index is serviced first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Global enable for servicing requests |
| en_set | input | NSRC | Pulse to set the per-source enable bits |
| req | input | NSRC | Request pulses, one per source |
| irq | output | NSRC | Interrupt pulses to the CPU, one per source |
| xfer_en | output | NSRC | Current per-source enable bits |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Access size code: 00 byte, 01 half, 10 word |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, in the low bytes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |

## Verification
The main function is driven through a vector table. Each vector gives a source, a unit size, two address modes, the interrupt bit and a starting count. Together the vectors cover the cases that must be told apart: a fixed source with an incrementing destination, both addresses incrementing, both addresses decrementing with the per-transfer interrupt, and fixed addresses with a zero starting count. The checks compare the moved bytes, the untouched neighbouring byte, the three written-back words and the number of interrupt pulses. These results separate size decoding, step direction and the final-count interrupt from the per-transfer interrupt. Directed tests cover the bypass with run low, the bypass after the enable bit self-clears, the lowest-index order for simultaneous requests, and a request held while another source is being serviced.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_VEC, ST_VECW, ST_CTL, ST_SAR, ST_DAR, ST_CNT,
        ST_SRC, ST_DST, ST_WSAR, ST_WDAR, ST_WCNT, ST_FIN
    } st_e;

    typedef struct packed {
        logic       every;   // irq after each transfer
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] size;
    } ctl_t;

    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] AM_INC  = 2'b10;
    localparam logic [1:0] AM_DEC  = 2'b11;

    function automatic logic [31:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 32'd1;
            2'b01:   return 32'd2;
            default: return 32'd4;
        endcase
    endfunction

    function automatic logic [31:0] step_addr(input logic [31:0] a,
                                              input logic [1:0]  am,
                                              input logic [1:0]  sz);
        case (am)
            AM_INC:  return a + unit_bytes(sz);
            AM_DEC:  return a - unit_bytes(sz);
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/evt_arb.sv
module evt_arb #(
    parameter int NSRC = 4,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   pend,
    output logic              valid,
    output logic [SEL_W-1:0]  sel
);
    logic [NSRC-1:0] oh;

    always_comb begin
        sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) sel = SEL_W'(i);
        end
    end

    assign valid = |pend;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_oh
            if (g == 0) begin : g_first
                assign oh[g] = pend[g];
            end else begin : g_rest
                assign oh[g] = pend[g] & ~|pend[g-1:0];
            end
        end
    endgenerate

    p_single_winner_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oh) && (valid -> oh[sel]));

endmodule

// File: rtl/evt_gate.sv
module evt_gate #(
    parameter int NSRC = 4,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [NSRC-1:0]   en_set,
    input  logic [NSRC-1:0]   req,
    input  logic              fin,
    input  logic [SEL_W-1:0]  fin_sel,
    input  logic              fin_zero,
    input  logic              fin_irq,
    output logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   irq
);
    logic [NSRC-1:0] clr, done, fin_hot, en_eff, take, byp;

    always_comb begin
        clr     = '0;
        done    = '0;
        fin_hot = '0;
        if (fin) begin
            done[fin_sel] = 1'b1;
            if (fin_zero) clr[fin_sel] = 1'b1;
            if (fin_irq)  fin_hot[fin_sel] = 1'b1;
        end
    end

    assign en_eff = en & ~clr;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign take[g] = req[g] & run & en_eff[g];
            assign byp[g]  = req[g] & ~take[g];

            p_bypass_irq_r2: assert property (@(posedge clk) disable iff (rst)
                req[g] && !run |=> irq[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            pend <= '0;
            irq  <= '0;
        end else begin
            en   <= en_eff | en_set;
            pend <= (pend & ~done) | take;
            irq  <= byp | fin_hot;
        end
    end

    p_zero_clears_en_r7: assert property (@(posedge clk) disable iff (rst)
        fin && fin_zero && !en_set[fin_sel] |=> !en[$past(fin_sel)]);

endmodule

// File: rtl/evt_engine.sv
module evt_engine
    import evt_pkg::*;
#(
    parameter int              NSRC     = 4,
    parameter int              ADDR_W   = 16,
    parameter logic [31:0]     VEC_BASE = 32'h0,
    localparam int             SEL_W    = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pvalid,
    input  logic [SEL_W-1:0]   psel,
    output logic               fin,
    output logic [SEL_W-1:0]   fin_sel,
    output logic               fin_zero,
    output logic               fin_irq,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_size,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);
    st_e               st;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] dbase, sar, dar;
    logic [15:0]       cnt;
    ctl_t              ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            sel   <= '0;
            dbase <= '0;
            sar   <= '0;
            dar   <= '0;
            cnt   <= '0;
            ctl   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (pvalid) begin
                    sel <= psel;
                    st  <= ST_VEC;
                end
                ST_VEC:  st <= ST_VECW;
                ST_VECW: begin dbase <= mem_rdata[ADDR_W-1:0]; st <= ST_CTL; end
                ST_CTL:  st <= ST_SAR;
                ST_SAR:  begin
                    ctl <= '{every: mem_rdata[9], dmode: mem_rdata[7:6],
                             smode: mem_rdata[5:4], size: mem_rdata[3:2]};
                    st  <= ST_DAR;
                end
                ST_DAR:  begin sar <= mem_rdata[ADDR_W-1:0]; st <= ST_CNT; end
                ST_CNT:  begin dar <= mem_rdata[ADDR_W-1:0]; st <= ST_SRC; end
                ST_SRC:  begin cnt <= mem_rdata[15:0]; st <= ST_DST; end
                ST_DST:  begin
                    sar <= ADDR_W'(step_addr(32'(sar), ctl.smode, ctl.size));
                    dar <= ADDR_W'(step_addr(32'(dar), ctl.dmode, ctl.size));
                    cnt <= cnt - 16'd1;
                    st  <= ST_WSAR;
                end
                ST_WSAR: st <= ST_WDAR;
                ST_WDAR: st <= ST_WCNT;
                ST_WCNT: st <= ST_FIN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_size  = SZ_WORD;
        mem_addr  = dbase;
        mem_wdata = '0;
        case (st)
            ST_VEC:  mem_addr = ADDR_W'(VEC_BASE) + ADDR_W'({sel, 2'b00});
            ST_CTL:  mem_addr = dbase;
            ST_SAR:  mem_addr = dbase + ADDR_W'(4);
            ST_DAR:  mem_addr = dbase + ADDR_W'(8);
            ST_CNT:  mem_addr = dbase + ADDR_W'(12);
            ST_SRC:  begin mem_addr = sar; mem_size = ctl.size; end
            ST_DST:  begin
                mem_we = 1'b1; mem_addr = dar; mem_size = ctl.size;
                mem_wdata = mem_rdata;
            end
            ST_WSAR: begin mem_we = 1'b1; mem_addr = dbase + ADDR_W'(4);  mem_wdata = 32'(sar); end
            ST_WDAR: begin mem_we = 1'b1; mem_addr = dbase + ADDR_W'(8);  mem_wdata = 32'(dar); end
            ST_WCNT: begin mem_we = 1'b1; mem_addr = dbase + ADDR_W'(12); mem_wdata = 32'(cnt); end
            default: mem_req = 1'b0;
        endcase
    end

    assign fin      = (st == ST_FIN);
    assign fin_sel  = sel;
    assign fin_zero = (cnt == 16'd0);
    assign fin_irq  = fin_zero | ctl.every;

    p_fin_then_idle_r10: assert property (@(posedge clk) disable iff (rst)
        st == ST_FIN |=> st == ST_IDLE);

    p_write_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        st == ST_DST |-> $past(mem_req && !mem_we));

    p_idle_no_access_r2: assert property (@(posedge clk) disable iff (rst)
        !pvalid && st == ST_IDLE |=> !mem_req);

endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl #(
    parameter int          NSRC     = 4,
    parameter int          ADDR_W   = 16,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [NSRC-1:0]    en_set,
    input  logic [NSRC-1:0]    req,
    output logic [NSRC-1:0]    irq,
    output logic [NSRC-1:0]    xfer_en,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_size,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);
    localparam int SEL_W = $clog2(NSRC);

    logic [NSRC-1:0]  pend;
    logic             pvalid, fin, fin_zero, fin_irq;
    logic [SEL_W-1:0] psel, fin_sel;

    evt_arb #(.NSRC(NSRC)) u_arb (
        .clk(clk), .rst(rst), .pend(pend), .valid(pvalid), .sel(psel)
    );

    evt_gate #(.NSRC(NSRC)) u_gate (
        .clk(clk), .rst(rst), .run(run), .en_set(en_set), .req(req),
        .fin(fin), .fin_sel(fin_sel), .fin_zero(fin_zero), .fin_irq(fin_irq),
        .pend(pend), .en(xfer_en), .irq(irq)
    );

    evt_engine #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_eng (
        .clk(clk), .rst(rst), .pvalid(pvalid), .psel(psel),
        .fin(fin), .fin_sel(fin_sel), .fin_zero(fin_zero), .fin_irq(fin_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0) && (xfer_en == '0) && !mem_req);

endmodule

// File: tb/sim_evt_xfer_ctrl.sv
module sim_evt_xfer_ctrl;
    localparam int NSRC = 4;
    localparam int AW   = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run = 1'b0;
    logic [NSRC-1:0] en_set = '0;
    logic [NSRC-1:0] req = '0;
    logic [NSRC-1:0] irq, xfer_en;
    logic            mem_req, mem_we;
    logic [1:0]      mem_size;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;

    always #2.5 clk = ~clk;

    evt_xfer_ctrl #(.NSRC(NSRC), .ADDR_W(AW), .VEC_BASE(32'h0)) u0 (
        .clk(clk), .rst(rst), .run(run), .en_set(en_set), .req(req),
        .irq(irq), .xfer_en(xfer_en), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // byte-addressed memory, one-cycle read latency
    logic [7:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            int a;
            a = int'(mem_addr[9:0]);
            if (mem_we) begin
                mem[a] <= mem_wdata[7:0];
                if (mem_size != 2'b00) mem[a+1] <= mem_wdata[15:8];
                if (mem_size == 2'b10) begin
                    mem[a+2] <= mem_wdata[23:16];
                    mem[a+3] <= mem_wdata[31:24];
                end
            end else begin
                case (mem_size)
                    2'b00:   mem_rdata <= {24'h0, mem[a]};
                    2'b01:   mem_rdata <= {16'h0, mem[a+1], mem[a]};
                    default: mem_rdata <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
                endcase
            end
        end
    end

    int irq_cnt [NSRC];
    logic        armed = 1'b0;
    logic [AW-1:0] first_wr;
    logic        got_wr;
    always @(negedge clk) begin
        for (int i = 0; i < NSRC; i++) if (irq[i]) irq_cnt[i]++;
        if (armed && !got_wr && mem_req && mem_we) begin
            got_wr   <= 1'b1;
            first_wr <= mem_addr;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    task automatic wr32(input int a, input logic [31:0] v);
        mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic setup(input int s, input logic [1:0] sz, input logic [1:0] sm,
                         input logic [1:0] dm, input logic every,
                         input logic [15:0] sa, input logic [15:0] da, input logic [15:0] c);
        int base;
        base = 'h100 + 'h20 * s;
        wr32(4 * s, 32'(base));
        wr32(base,      {22'h0, every, 1'b0, dm, sm, sz, 2'b00});
        wr32(base + 4,  32'(sa));
        wr32(base + 8,  32'(da));
        wr32(base + 12, 32'(c));
    endtask

    task automatic pulse_en(input logic [NSRC-1:0] m);
        en_set = m; tick(1); en_set = '0;
    endtask

    task automatic pulse_req(input logic [NSRC-1:0] m);
        req = m; tick(1); req = '0;
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    typedef struct packed {
        logic [1:0]  src;
        logic [1:0]  sz, sm, dm;
        logic        every;
        logic [15:0] sa, da, c;
        logic [15:0] esa, eda, ec;
        logic [3:0]  eirq;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0300, 16'h0340, 16'd3,
          16'h0300, 16'h0341, 16'd2,     4'd0},
        '{2'd1, 2'b01, 2'b10, 2'b10, 1'b0, 16'h0310, 16'h0350, 16'd1,
          16'h0312, 16'h0352, 16'd0,     4'd1},
        '{2'd2, 2'b10, 2'b11, 2'b11, 1'b1, 16'h0320, 16'h0360, 16'd5,
          16'h031C, 16'h035C, 16'd4,     4'd1},
        '{2'd3, 2'b00, 2'b01, 2'b00, 1'b0, 16'h0330, 16'h0370, 16'd0,
          16'h0330, 16'h0370, 16'hFFFF,  4'd0}
    };

    initial begin : watchdog
        #500000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < 1024; a++) mem[a] = pat(a);
        for (int a = 'h340; a < 'h380; a++) mem[a] = 8'h00;
        for (int i = 0; i < NSRC; i++) irq_cnt[i] = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 xfer_en", 32'(xfer_en), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        tick(1);

        // R2: run low -> bypass
        setup(0, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0300, 16'h0340, 16'd3);
        pulse_en(4'b0001);
        req = 4'b0001; @(posedge clk); #1; req = '0;
        @(negedge clk);
        chk("R2 bypass irq", 32'(irq), 32'h1);
        chk("R2 no access", 32'(mem_req), 0);
        tick(20);
        chk("R2 count untouched", rd32('h10C), 32'd3);

        // table walk
        run = 1'b1;
        for (int v = 0; v < 4; v++) begin
            int s, n;
            s = int'(VECS[v].src);
            n = nbytes(VECS[v].sz);
            setup(s, VECS[v].sz, VECS[v].sm, VECS[v].dm, VECS[v].every,
                  VECS[v].sa, VECS[v].da, VECS[v].c);
            pulse_en(4'(1 << s));
            irq_cnt[s] = 0;
            pulse_req(4'(1 << s));
            tick(30);
            for (int b = 0; b < n; b++)
                chk($sformatf("R4 data v%0d b%0d", v, b), 32'(mem[int'(VECS[v].da) + b]),
                    32'(pat(int'(VECS[v].sa) + b)));
            chk($sformatf("R4 neighbour v%0d", v), 32'(mem[int'(VECS[v].da) + n]), 0);
            chk($sformatf("R5 R6 sar v%0d", v), rd32('h104 + 'h20 * s), 32'(VECS[v].esa));
            chk($sformatf("R5 R6 dar v%0d", v), rd32('h108 + 'h20 * s), 32'(VECS[v].eda));
            chk($sformatf("R3 R6 cnt v%0d", v), rd32('h10C + 'h20 * s), 32'(VECS[v].ec));
            chk($sformatf("R7 R8 R9 irq v%0d", v), 32'(irq_cnt[s]), 32'(VECS[v].eirq));
        end

        // R7: enable cleared after zero, later requests bypass
        chk("R7 en cleared", 32'(xfer_en[1]), 0);
        chk("R7 others kept", 32'(xfer_en[0]), 1);
        req = 4'b0010; @(posedge clk); #1; req = '0;
        @(negedge clk);
        chk("R7 bypass irq", 32'(irq[1]), 1);
        tick(30);
        chk("R7 desc unchanged", rd32('h12C), 0);

        // R10: simultaneous requests, lowest first
        setup(0, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0300, 16'h0344, 16'd10);
        setup(3, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0301, 16'h0374, 16'd10);
        pulse_en(4'b1001);
        got_wr = 1'b0; armed = 1'b1;
        pulse_req(4'b1001);
        tick(60);
        armed = 1'b0;
        chk("R10 first write src0", 32'(first_wr), 32'h0344);
        chk("R10 src0 cnt", rd32('h10C), 32'd9);
        chk("R10 src3 cnt", rd32('h16C), 32'd9);

        // R10: request held while busy
        irq_cnt[2] = 0;
        pulse_req(4'b0100);
        tick(3);
        pulse_req(4'b0001);
        tick(60);
        chk("R10 busy src2 cnt", rd32('h14C), 32'd3);
        chk("R10 held src0 cnt", rd32('h10C), 32'd8);
        chk("R8 every-transfer irq", 32'(irq_cnt[2]), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule